// File: doc/BRIEF.md
# Divided System Clock Bank with Coordinated Restart

This block produces several divided system clocks from one reference clock. Each output has its own divide ratio, which can be set from 1 to 32. After a power-on reset the bank is in bypass, and every output carries the reference clock. A mode write switches the outputs to the divided path. A one-cycle restart request starts a coordinated restart. Each output runs to the end of the period it is in and then parks low. Once the last output has parked, all outputs stay low for a fixed quiet interval of ten reference cycles. All outputs then start again on the same reference edge, using the built-in default ratios.

There are two resets. Power-on reset clears everything, including the ratios and the mode. The ordinary reset only realigns the counters and the restart sequencer. The programmed ratios and the selected mode are kept.

Top module: `divclk_bank`

## Requirements
- R1: Output i takes its ratio field from `ratio_in` bits [5i+4:5i]. The field value m selects divide-by-N, where N = m+1. When N is 2 or more, the output has a period of N reference cycles and is high for the first floor(N/2) cycles of each period. For even N this gives an exact 50% duty cycle. When N = 1 the output follows the reference clock.
- R2: After a restart request is accepted, each output finishes the period it is in, counting from the edge that accepted the request. The output is then held low.
- R3: From the edge on which the last output parks, all outputs stay low for exactly 10 reference cycles.
- R4: At the end of the quiet interval, every output restarts on the same reference edge. The restart uses the default ratios, and every output with N of 2 or more begins with its high phase.
- R5: `busy` goes high one cycle after an accepted restart request and stays high until the outputs resume. A restart request that arrives while `busy` is high has no effect, and the quiet interval keeps its length.
- R6: Power-on reset loads the default ratios and selects bypass. In bypass `pll_active` is 0 and every output equals the reference clock.
- R7: The ordinary reset `rst` restarts every divider at the beginning of its period. It leaves the ratios and `pll_active` unchanged.
- R8: When no reset is active, `ratio_we` loads `ratio_in` on the next edge, unless a restart is in progress. `mode_we` loads `mode_pll` into `pll_active` on the next edge, and a value of 1 selects the divided outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Ordinary reset, synchronous, active high; keeps the ratios and the mode |
| restart_req | input | 1 | Request for a coordinated pause and restart |
| ratio_we | input | 1 | Ratio write strobe |
| ratio_in | input | 15 | Three 5-bit fields, each holding divide ratio minus one |
| mode_we | input | 1 | Mode write strobe |
| mode_pll | input | 1 | 1 selects the divided path, 0 selects bypass |
| sysclk | output | 3 | System clock outputs |
| busy | output | 1 | High while a restart is in progress |
| pll_active | output | 1 | 1 when the divided path is driving the outputs |

## Verification
The divided outputs are decoded from counter registers. A counter reset, a ratio load or a mode load therefore shows up in the sample taken right after the edge that captured it. `busy` rises in the sample after the request edge. An output is last seen running in the sample where its counter shows the final cycle of its period, and it reads low from the next sample on. The 10 quiet samples follow the sample in which the last output parks, and the eleventh sample after that shows `busy` low and every divided output high. The bench samples 2 ns after each rising edge and predicts each of these sample indices from the ratios. In bypass it also samples in the middle of the low phase, to confirm that the outputs follow the reference clock.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

    localparam int RATIO_W   = 5;
    localparam int PAUSE_LEN = 10;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_DRAIN = 2'd1,
        SEQ_PAUSE = 2'd2
    } seq_state_e;

    // Control broadcast from the sequencer to every channel
    typedef struct packed {
        logic drain;
        logic reload;
    } chan_ctl_t;

    // Number of high cycles for a ratio field m (divide by m+1)
    function automatic ratio_t high_len(ratio_t m1);
        logic [RATIO_W:0] w;
        w = {1'b0, m1} + 1'b1;
        return ratio_t'(w >> 1);
    endfunction

endpackage

// File: rtl/divclk_chan.sv
module divclk_chan
    import divclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ratio_t    ratio_m1,
    input  chan_ctl_t ctl,
    output logic      done_next,
    output logic      div_out
);

    ratio_t cnt;
    logic   stop;
    logic   last;

    assign last      = (cnt >= ratio_m1);
    assign done_next = stop | last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            stop <= 1'b0;
        end else if (ctl.reload) begin
            cnt  <= '0;
            stop <= 1'b0;
        end else if (!stop) begin
            if (last) begin
                cnt  <= '0;
                stop <= ctl.drain;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (stop)
            div_out = 1'b0;
        else if (ratio_m1 == '0)
            div_out = clk;
        else
            div_out = (cnt < high_len(ratio_m1));
    end

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !ctl.reload) |=> (stop && $stable(cnt)));

    // R2
    stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop) |-> $past(last));

endmodule

// File: rtl/divclk_seq.sv
module divclk_seq
    import divclk_pkg::*;
#(
    parameter int NUM_OUT    = 3,
    parameter int PAUSE_CYC  = PAUSE_LEN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart_req,
    input  logic [NUM_OUT-1:0] done_next,
    output logic               busy,
    output chan_ctl_t          ctl
);

    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam logic [PW-1:0] PCNT_LAST = PW'(PAUSE_CYC - 1);

    seq_state_e      state;
    logic [PW-1:0]   pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_RUN;
            pcnt  <= '0;
        end else begin
            case (state)
                SEQ_RUN: begin
                    if (restart_req)
                        state <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (&done_next) begin
                        state <= SEQ_PAUSE;
                        pcnt  <= '0;
                    end
                end
                SEQ_PAUSE: begin
                    if (pcnt == PCNT_LAST)
                        state <= SEQ_RUN;
                    else
                        pcnt <= pcnt + 1'b1;
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    assign busy       = (state != SEQ_RUN);
    assign ctl.drain  = (state == SEQ_DRAIN);
    assign ctl.reload = (state == SEQ_PAUSE) && (pcnt == PCNT_LAST);

    // R3
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_PAUSE) |-> (&done_next));

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_PAUSE && restart_req && !ctl.reload) |=> (state == SEQ_PAUSE));

endmodule

// File: rtl/divclk_cfg.sv
module divclk_cfg
    import divclk_pkg::*;
#(
    parameter int                         NUM_OUT  = 3,
    parameter logic [NUM_OUT*RATIO_W-1:0] DEF_RATIO = '0
) (
    input  logic                              clk,
    input  logic                              por,
    input  logic                              rst,
    input  logic                              busy,
    input  logic                              reload,
    input  logic                              ratio_we,
    input  logic [NUM_OUT*RATIO_W-1:0]        ratio_in,
    input  logic                              mode_we,
    input  logic                              mode_pll,
    output logic [NUM_OUT-1:0][RATIO_W-1:0]   ratio_q,
    output logic                              pll_on
);

    always_ff @(posedge clk) begin
        if (por) begin
            ratio_q <= DEF_RATIO;
            pll_on  <= 1'b0;
        end else if (!rst) begin
            if (reload)
                ratio_q <= DEF_RATIO;
            else if (ratio_we && !busy)
                ratio_q <= ratio_in;
            if (mode_we)
                pll_on <= mode_pll;
        end
    end

    // R6
    por_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        por |=> (!pll_on && ratio_q == DEF_RATIO));

    // R7
    rst_keep_chk: assert property (@(posedge clk) disable iff (por)
        rst |=> ($stable(ratio_q) && $stable(pll_on)));

endmodule

// File: rtl/divclk_bank.sv
module divclk_bank
    import divclk_pkg::*;
#(
    parameter int                         NUM_OUT      = 3,
    parameter logic [NUM_OUT*RATIO_W-1:0] DEF_RATIOS   = {5'd5, 5'd3, 5'd1},
    parameter int                         PAUSE_CYCLES = PAUSE_LEN
) (
    input  logic                       clk,
    input  logic                       por,
    input  logic                       rst,
    input  logic                       restart_req,
    input  logic                       ratio_we,
    input  logic [NUM_OUT*RATIO_W-1:0] ratio_in,
    input  logic                       mode_we,
    input  logic                       mode_pll,
    output logic [NUM_OUT-1:0]         sysclk,
    output logic                       busy,
    output logic                       pll_active
);

    logic                            rst_any;
    logic [NUM_OUT-1:0][RATIO_W-1:0] ratio_q;
    logic [NUM_OUT-1:0]              done_next;
    logic [NUM_OUT-1:0]              div_w;
    chan_ctl_t                       ctl;
    logic                            pll_on;

    assign rst_any    = rst | por;
    assign pll_active = pll_on;

    divclk_cfg #(
        .NUM_OUT   (NUM_OUT),
        .DEF_RATIO (DEF_RATIOS)
    ) u_cfg (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .busy     (busy),
        .reload   (ctl.reload),
        .ratio_we (ratio_we),
        .ratio_in (ratio_in),
        .mode_we  (mode_we),
        .mode_pll (mode_pll),
        .ratio_q  (ratio_q),
        .pll_on   (pll_on)
    );

    divclk_seq #(
        .NUM_OUT   (NUM_OUT),
        .PAUSE_CYC (PAUSE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst_any),
        .restart_req (restart_req),
        .done_next   (done_next),
        .busy        (busy),
        .ctl         (ctl)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        divclk_chan u_chan (
            .clk       (clk),
            .rst       (rst_any),
            .ratio_m1  (ratio_q[g]),
            .ctl       (ctl),
            .done_next (done_next[g]),
            .div_out   (div_w[g])
        );

        assign sysclk[g] = pll_on ? div_w[g] : clk;

        // R4
        resume_align_chk: assert property (@(posedge clk) disable iff (rst_any)
            ($fell(busy) && ratio_q[g] != '0) |-> div_w[g]);
    end

    // R4
    resume_default_chk: assert property (@(posedge clk) disable iff (rst_any)
        $fell(busy) |-> (ratio_q == DEF_RATIOS));

endmodule

// File: tb/divclk_bank_test.sv
module divclk_bank_test;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic        restart_req = 1'b0;
    logic        ratio_we = 1'b0;
    logic [14:0] ratio_in = '0;
    logic        mode_we = 1'b0;
    logic        mode_pll = 1'b0;
    logic [2:0]  sysclk;
    logic        busy;
    logic        pll_active;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    int exp_m[3];

    always #4 clk = ~clk;

    divclk_bank uut (
        .clk         (clk),
        .por         (por),
        .rst         (rst),
        .restart_req (restart_req),
        .ratio_we    (ratio_we),
        .ratio_in    (ratio_in),
        .mode_we     (mode_we),
        .mode_pll    (mode_pll),
        .sysclk      (sysclk),
        .busy        (busy),
        .pll_active  (pll_active)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wave(int m, int c);
        if (m == 0) return 1;
        return (c < (m + 1) / 2) ? 1 : 0;
    endfunction

    task automatic set_defaults();
        exp_m[0] = 1; exp_m[1] = 3; exp_m[2] = 5;
    endtask

    task automatic align();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic check_wave(int n, string req);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 3; i++)
                chk(req, $sformatf("sysclk[%0d] sample %0d", i, k),
                    int'(sysclk[i]), wave(exp_m[i], k % (exp_m[i] + 1)));
            tick();
        end
    endtask

    task automatic check_bypass(string req);
        chk(req, "pll_active in bypass", int'(pll_active), 0);
        chk(req, "outputs in high phase", int'(sysclk), 7);
        #4;
        chk(req, "outputs in low phase", int'(sysclk), 0);
        tick();
    endtask

    task automatic t_power_on();
        repeat (3) tick();
        por = 1'b0;
        chk("R5", "busy after power-on", int'(busy), 0);
        check_bypass("R6");
    endtask

    task automatic t_default_div();
        mode_we = 1'b1; mode_pll = 1'b1;
        tick();
        mode_we = 1'b0;
        chk("R8", "pll_active after mode write", int'(pll_active), 1);
        align();
        set_defaults();
        check_wave(24, "R1");
    endtask

    task automatic t_program();
        ratio_in = {5'd0, 5'd2, 5'd31};
        ratio_we = 1'b1;
        tick();
        ratio_we = 1'b0;
        align();
        exp_m[0] = 31; exp_m[1] = 2; exp_m[2] = 0;
        check_wave(70, "R1");
    endtask

    task automatic t_rst_keep();
        repeat (7) tick();
        align();
        chk("R7", "pll_active kept through rst", int'(pll_active), 1);
        check_wave(40, "R7");
    endtask

    task automatic t_restart();
        int ti[3];
        int tmax;
        int n;
        align();
        repeat (5) tick();
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        tmax = 0;
        for (int i = 0; i < 3; i++) begin
            n = exp_m[i] + 1;
            ti[i] = 0;
            while (((6 + ti[i]) % n) != n - 1) ti[i]++;
            if (ti[i] > tmax) tmax = ti[i];
        end
        for (int t = 0; t <= tmax + 10; t++) begin
            if (t == tmax + 3) restart_req = 1'b1;
            chk("R5", $sformatf("busy at restart sample %0d", t), int'(busy), 1);
            for (int i = 0; i < 3; i++) begin
                n = exp_m[i] + 1;
                chk((t <= tmax) ? "R2" : "R3",
                    $sformatf("sysclk[%0d] restart sample %0d", i, t),
                    int'(sysclk[i]),
                    (t <= ti[i]) ? wave(exp_m[i], (6 + t) % n) : 0);
            end
            tick();
            restart_req = 1'b0;
        end
        chk("R5", "busy clear after pause", int'(busy), 0);
        set_defaults();
        check_wave(24, "R4");
    endtask

    task automatic t_por_again();
        ratio_in = {5'd0, 5'd2, 5'd31};
        ratio_we = 1'b1;
        tick();
        ratio_we = 1'b0;
        por = 1'b1;
        tick();
        por = 1'b0;
        check_bypass("R6");
        mode_we = 1'b1; mode_pll = 1'b1;
        tick();
        mode_we = 1'b0;
        align();
        set_defaults();
        check_wave(24, "R6");
    endtask

    initial begin
        t_power_on();
        t_default_div();
        t_program();
        t_rst_keep();
        t_restart();
        t_por_again();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule